// File: doc/BRIEF.md
# Perspective-Correct Span Texture Interpolator

This block produces a texture coordinate pair for every pixel along one horizontal run of a triangle, with perspective foreshortening applied. A setup strobe hands it three screen-linear quantities at the span's left end: texture-u divided by w, texture-v divided by w, and the inverse depth 1/w. Along with them come one x-increment for each quantity, a starting x position and a pixel count. For each pixel the block forms w as the reciprocal of the current inverse depth. It multiplies w by the two divided coordinates to recover u and v, and then adds the increments to step to the next pixel.

The reciprocal comes from a serial restoring divider that is part of the block. Only one pixel is in flight at any time. Each result is presented on a valid/ready output together with its x position. The next pixel's division begins only when the downstream side has taken the current result. Edge walking, per-vertex setup and texture fetch are handled elsewhere.

Top module: `psi_span`

## Requirements
- R1: Pixel k of a span (k counting from 0) uses u/w = start + k*du, v/w = start + k*dv and 1/w = start + k*dw. Each sum wraps modulo 2^24 and every increment is read as a 24-bit two's complement number.
- R2: For a nonzero 1/w value q above 2048 (unsigned Q1.23), w = floor(2^35 / q) as unsigned Q12.12. The output u is bits 35..12 of the signed product (u/w)·w, with u/w a signed Q8.16 value, and v is formed the same way, so each output is signed Q8.16.
- R3: For 1 ≤ q ≤ 2048 the reciprocal saturates to w = 2^24 − 1 before the multiply.
- R4: A pixel whose 1/w is exactly zero is presented with the error flag high and u = v = 0. The flag is low for every other pixel.
- R5: The x position of pixel k is the loaded start x plus k, wrapping modulo 2^12.
- R6: A span loaded with count N > 0 presents exactly N results. The done output pulses for one cycle, in the cycle right after the last result is accepted, and busy is high from the cycle after the load until then.
- R7: A load with count zero presents no result, leaves busy low and pulses done in the cycle after the load.
- R8: While valid is high and ready is low, valid, u, v, x and the error flag all stay unchanged, and the span does not advance.
- R9: A load strobe that arrives while busy is high is ignored.
- R10: A result becomes valid exactly 25 clock edges after the edge that accepted the load or the edge that accepted the previous result of the span.
- R11: After reset, valid, busy, done and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_ld | input | 1 | Span load strobe, taken only while idle |
| i_x0 | input | 12 | Start x position |
| i_uq | input | 24 | Start u/w, signed Q8.16 |
| i_vq | input | 24 | Start v/w, signed Q8.16 |
| i_iw | input | 24 | Start 1/w, unsigned Q1.23 |
| i_duq | input | 24 | Per-pixel increment of u/w |
| i_dvq | input | 24 | Per-pixel increment of v/w |
| i_diw | input | 24 | Per-pixel increment of 1/w, two's complement |
| i_cnt | input | 12 | Number of pixels in the span |
| o_valid | output | 1 | Result valid |
| i_ready | input | 1 | Downstream accepts the result |
| o_x | output | 12 | x position of the result |
| o_u | output | 24 | Perspective-correct u, signed Q8.16 |
| o_v | output | 24 | Perspective-correct v, signed Q8.16 |
| o_err | output | 1 | Result came from a zero 1/w |
| o_busy | output | 1 | A span is in progress |
| o_done | output | 1 | One-cycle pulse at span end |

## Verification
Every result is due 25 edges after the edge that started its division, which is either the load edge or the accept edge of the previous pixel. The bench records the cycle number of each such edge and checks that valid first appears exactly 25 cycles later. Done is due on the edge right after the final accept, or right after a zero-count load, and the bench compares its arrival against the cycle it expects. All outputs are sampled on the falling edge. The ready value that decides whether a result is accepted is chosen at that same falling edge, so every result is compared, and any stall is recorded, before the edge that acts on it.

// File: rtl/psi_pkg.sv
package psi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } psi_state_e;

  localparam int LANES = 3;
  localparam int LN_U  = 0;
  localparam int LN_V  = 1;
  localparam int LN_IW = 2;

endpackage

// File: rtl/psi_recip.sv
module psi_recip #(
  parameter int DEN_W = 24,
  parameter int QW    = 24,
  parameter int PRE   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [QW-1:0]    quo,
  output logic             zero
);
  localparam int CW = $clog2(QW + 1);
  localparam logic [DEN_W:0] REM0 = (DEN_W + 1)'(1) << PRE;

  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] dv;
  logic [QW-1:0]    qacc;
  logic [CW-1:0]    cnt;
  logic             sat;

  logic [DEN_W:0] shl;
  logic [DEN_W:0] dif;
  logic           ge;

  always_comb begin
    shl = {rem[DEN_W-1:0], 1'b0};
    ge  = (shl >= {1'b0, dv});
    dif = shl - {1'b0, dv};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      dv   <= '0;
      qacc <= '0;
      cnt  <= '0;
      sat  <= 1'b0;
      fin  <= 1'b0;
      quo  <= '0;
      zero <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem  <= REM0;
        dv   <= den;
        qacc <= '0;
        cnt  <= CW'(QW);
        sat  <= ({1'b0, den} <= REM0);
        zero <= (den == '0);
      end else if (cnt != '0) begin
        rem  <= ge ? dif : shl;
        qacc <= {qacc[QW-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          fin <= 1'b1;
          quo <= sat ? '1 : {qacc[QW-2:0], ge};
        end
      end
    end
  end

endmodule

// File: rtl/psi_span_acc.sv
module psi_span_acc
  import psi_pkg::*;
#(
  parameter int AW = 24,
  parameter int XW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          adv,
  input  logic [XW-1:0] ld_x,
  input  logic [AW-1:0] ld_uq,
  input  logic [AW-1:0] ld_vq,
  input  logic [AW-1:0] ld_iw,
  input  logic [AW-1:0] ld_duq,
  input  logic [AW-1:0] ld_dvq,
  input  logic [AW-1:0] ld_diw,
  output logic [XW-1:0] x,
  output logic [AW-1:0] uq,
  output logic [AW-1:0] vq,
  output logic [AW-1:0] iw,
  output logic [AW-1:0] iw_nxt
);
  logic [AW-1:0] init_a [LANES];
  logic [AW-1:0] step_a [LANES];
  logic [AW-1:0] acc_a  [LANES];
  logic [AW-1:0] del_a  [LANES];

  assign init_a[LN_U]  = ld_uq;
  assign init_a[LN_V]  = ld_vq;
  assign init_a[LN_IW] = ld_iw;
  assign step_a[LN_U]  = ld_duq;
  assign step_a[LN_V]  = ld_dvq;
  assign step_a[LN_IW] = ld_diw;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_a[g] <= '0;
        del_a[g] <= '0;
      end else if (ld) begin
        acc_a[g] <= init_a[g];
        del_a[g] <= step_a[g];
      end else if (adv) begin
        acc_a[g] <= acc_a[g] + del_a[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0;
    end else if (ld) begin
      x <= ld_x;
    end else if (adv) begin
      x <= x + 1'b1;
    end
  end

  assign uq     = acc_a[LN_U];
  assign vq     = acc_a[LN_V];
  assign iw     = acc_a[LN_IW];
  assign iw_nxt = acc_a[LN_IW] + del_a[LN_IW];

endmodule

// File: rtl/psi_persp_mul.sv
module psi_persp_mul #(
  parameter int AW = 24,
  parameter int QW = 24,
  parameter int WF = 12
) (
  input  logic [AW-1:0] uq,
  input  logic [AW-1:0] vq,
  input  logic [QW-1:0] w,
  input  logic          zero,
  output logic [AW-1:0] u,
  output logic [AW-1:0] v
);
  localparam int PW = AW + QW + 1;

  logic signed [PW-1:0] wx;
  logic signed [PW-1:0] ax [2];
  logic signed [PW-1:0] px [2];
  logic        [AW-1:0] rx [2];

  assign wx    = {{(AW + 1){1'b0}}, w};
  assign ax[0] = {{(QW + 1){uq[AW-1]}}, uq};
  assign ax[1] = {{(QW + 1){vq[AW-1]}}, vq};

  for (genvar g = 0; g < 2; g++) begin : g_mul
    always_comb begin
      px[g] = ax[g] * wx;
      rx[g] = zero ? '0 : px[g][WF +: AW];
    end
  end

  assign u = rx[0];
  assign v = rx[1];

endmodule

// File: rtl/psi_span.sv
module psi_span
  import psi_pkg::*;
#(
  parameter int AW      = 24,
  parameter int IW_FRAC = 23,
  parameter int QW      = 24,
  parameter int WF      = 12,
  parameter int XW      = 12,
  parameter int CW      = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_ld,
  input  logic [XW-1:0] i_x0,
  input  logic [AW-1:0] i_uq,
  input  logic [AW-1:0] i_vq,
  input  logic [AW-1:0] i_iw,
  input  logic [AW-1:0] i_duq,
  input  logic [AW-1:0] i_dvq,
  input  logic [AW-1:0] i_diw,
  input  logic [CW-1:0] i_cnt,
  output logic          o_valid,
  input  logic          i_ready,
  output logic [XW-1:0] o_x,
  output logic [AW-1:0] o_u,
  output logic [AW-1:0] o_v,
  output logic          o_err,
  output logic          o_busy,
  output logic          o_done
);
  localparam int PRE = IW_FRAC + WF - QW;

  psi_state_e    st;
  logic [CW-1:0] rem;

  logic          take_ld, acc_out, last_px, div_start;
  logic [AW-1:0] div_den;
  logic          div_fin, div_zero;
  logic [QW-1:0] div_quo;

  logic [XW-1:0] a_x;
  logic [AW-1:0] a_uq, a_vq, a_iw, a_iw_nxt;
  logic [AW-1:0] m_u, m_v;

  always_comb begin
    take_ld   = (st == ST_IDLE) && i_ld;
    acc_out   = (st == ST_OUT) && i_ready;
    last_px   = (rem == CW'(1));
    div_start = (take_ld && (i_cnt != '0)) || (acc_out && !last_px);
    div_den   = (st == ST_IDLE) ? i_iw : a_iw_nxt;
  end

  psi_span_acc #(.AW(AW), .XW(XW)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .ld     (take_ld),
    .adv    (acc_out),
    .ld_x   (i_x0),
    .ld_uq  (i_uq),
    .ld_vq  (i_vq),
    .ld_iw  (i_iw),
    .ld_duq (i_duq),
    .ld_dvq (i_dvq),
    .ld_diw (i_diw),
    .x      (a_x),
    .uq     (a_uq),
    .vq     (a_vq),
    .iw     (a_iw),
    .iw_nxt (a_iw_nxt)
  );

  psi_recip #(.DEN_W(AW), .QW(QW), .PRE(PRE)) u_rcp (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .den   (div_den),
    .fin   (div_fin),
    .quo   (div_quo),
    .zero  (div_zero)
  );

  psi_persp_mul #(.AW(AW), .QW(QW), .WF(WF)) u_mul (
    .uq   (a_uq),
    .vq   (a_vq),
    .w    (div_quo),
    .zero (div_zero),
    .u    (m_u),
    .v    (m_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rem     <= '0;
      o_valid <= 1'b0;
      o_x     <= '0;
      o_u     <= '0;
      o_v     <= '0;
      o_err   <= 1'b0;
      o_done  <= 1'b0;
    end else begin
      o_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (i_ld) begin
            if (i_cnt == '0) begin
              o_done <= 1'b1;
            end else begin
              rem <= i_cnt;
              st  <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            o_valid <= 1'b1;
            o_x     <= a_x;
            o_u     <= m_u;
            o_v     <= m_v;
            o_err   <= div_zero;
            st      <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (i_ready) begin
            o_valid <= 1'b0;
            rem     <= rem - 1'b1;
            if (last_px) begin
              o_done <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              st <= ST_DIV;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign o_busy = (st != ST_IDLE);

  logic unused_iw;
  assign unused_iw = ^a_iw;

endmodule

// File: rtl/psi_span_chk.sv
module psi_span_chk #(
  parameter int AW = 24,
  parameter int QW = 24,
  parameter int XW = 12,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          i_ld,
  input logic [CW-1:0] i_cnt,
  input logic          o_valid,
  input logic          i_ready,
  input logic [XW-1:0] o_x,
  input logic [AW-1:0] o_u,
  input logic [AW-1:0] o_v,
  input logic          o_err,
  input logic          o_busy,
  input logic          o_done
);
  localparam int GW  = $clog2(QW + 8) + 1;
  localparam int LAT = QW + 2;

  logic [GW-1:0] gap;
  logic          ev;

  assign ev = (!o_busy && i_ld && (i_cnt != '0)) || (o_valid && i_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0;
    end else if (ev) begin
      gap <= GW'(1);
    end else if ((gap != '0) && !o_valid && (gap < GW'(LAT + 1))) begin
      gap <= gap + 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    o_valid && !i_ready |=> o_valid && $stable(o_u) && $stable(o_v) && $stable(o_x) && $stable(o_err));

  p_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
    o_valid && o_err |-> (o_u == '0) && (o_v == '0));

  p_zero_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    !o_busy && i_ld && (i_cnt == '0) |=> o_done && !o_busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    o_done |=> !o_done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    o_done |-> !o_busy && !o_valid);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    o_busy && i_ld && !(o_valid && i_ready) |=> o_busy && !o_done);

  p_valid_busy_r6: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> o_busy);

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(o_valid) |-> (gap == GW'(LAT)));

endmodule

bind psi_span psi_span_chk #(.AW(AW), .QW(QW), .XW(XW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .i_ld    (i_ld),
  .i_cnt   (i_cnt),
  .o_valid (o_valid),
  .i_ready (i_ready),
  .o_x     (o_x),
  .o_u     (o_u),
  .o_v     (o_v),
  .o_err   (o_err),
  .o_busy  (o_busy),
  .o_done  (o_done)
);

// File: tb/sim_psi_span.sv
`timescale 1ns/1ps
module sim_psi_span;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_ld = 1'b0;
  logic [11:0] i_x0 = '0;
  logic [23:0] i_uq = '0, i_vq = '0, i_iw = '0;
  logic [23:0] i_duq = '0, i_dvq = '0, i_diw = '0;
  logic [11:0] i_cnt = '0;
  logic        i_ready = 1'b1;
  logic        o_valid, o_err, o_busy, o_done;
  logic [11:0] o_x;
  logic [23:0] o_u, o_v;

  always #2.5 clk = ~clk;

  psi_span u0 (
    .clk(clk), .rst(rst), .i_ld(i_ld), .i_x0(i_x0), .i_uq(i_uq), .i_vq(i_vq),
    .i_iw(i_iw), .i_duq(i_duq), .i_dvq(i_dvq), .i_diw(i_diw), .i_cnt(i_cnt),
    .o_valid(o_valid), .i_ready(i_ready), .o_x(o_x), .o_u(o_u), .o_v(o_v),
    .o_err(o_err), .o_busy(o_busy), .o_done(o_done)
  );

  typedef struct {
    logic [11:0] x;
    logic [23:0] u;
    logic [23:0] v;
    logic        err;
    string       tag;
  } item_t;

  item_t  sbq[$];
  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  longint lat_ref = 0, exp_done = -1;
  bit     lat_pend = 0, span_done = 0, bp_mode = 0, prev_stall = 0;
  int     n_stray = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] h_u, h_v;
  logic [11:0] h_x;
  logic        h_err;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_w(logic [23:0] q);
    if (q <= 24'd2048) return '1;
    return 24'((64'd1 << 35) / {40'd0, q});
  endfunction

  function automatic logic [23:0] scale(logic [23:0] a, logic [23:0] w);
    longint p;
    p = longint'(signed'(a)) * longint'({40'd0, w});
    return p[35:12];
  endfunction

  // monitor: outputs sampled at falling edge; ready for the next edge chosen here
  always @(negedge clk) begin
    logic rdy_n;
    item_t e;
    if (!rst) begin
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy_n = bp_mode ? lfsr[0] : 1'b1;
      if (prev_stall) begin
        check(o_valid && o_u == h_u && o_v == h_v && o_x == h_x && o_err == h_err,
              "R8", "held output", {o_valid, o_u}, {1'b1, h_u});
      end
      if (lat_pend && o_valid) begin
        check(cyc - lat_ref == 26, "R10", "latency", cyc - lat_ref, 26);
        lat_pend = 0;
      end
      if (o_valid && rdy_n) begin
        if (sbq.size() == 0) begin
          n_stray++;
        end else begin
          e = sbq.pop_front();
          check(o_u == e.u, e.tag, "u", o_u, e.u);
          check(o_v == e.v, e.tag, "v", o_v, e.v);
          check(o_x == e.x, e.tag, "x (R5)", o_x, e.x);
          check(o_err == e.err, e.tag, "err (R4)", o_err, e.err);
          if (sbq.size() == 0) exp_done = cyc + 1;
          else begin
            lat_pend = 1;
            lat_ref  = cyc;
          end
        end
      end
      if (o_done) begin
        check(cyc == exp_done, "R6", "done cycle", cyc, exp_done);
        span_done = 1;
        exp_done  = -1;
      end
      prev_stall = o_valid && !rdy_n;
      h_u = o_u; h_v = o_v; h_x = o_x; h_err = o_err;
      i_ready = rdy_n;
    end
  end

  task automatic run_span(string tag, logic [11:0] x0, logic [23:0] uq, logic [23:0] vq,
                          logic [23:0] iw, logic [23:0] duq, logic [23:0] dvq,
                          logic [23:0] diw, logic [11:0] n, bit junk);
    logic [23:0] cu, cv, cw;
    logic [11:0] cx;
    item_t e;
    cu = uq; cv = vq; cw = iw; cx = x0;
    for (int k = 0; k < int'(n); k++) begin
      e.x   = cx;
      e.err = (cw == '0);
      e.u   = e.err ? '0 : scale(cu, exp_w(cw));
      e.v   = e.err ? '0 : scale(cv, exp_w(cw));
      e.tag = tag;
      sbq.push_back(e);
      cu = cu + duq; cv = cv + dvq; cw = cw + diw; cx = cx + 1'b1;
    end
    span_done = 0;
    @(negedge clk);
    i_ld = 1; i_x0 = x0; i_uq = uq; i_vq = vq; i_iw = iw;
    i_duq = duq; i_dvq = dvq; i_diw = diw; i_cnt = n;
    if (n == 0) exp_done = cyc + 1;
    else begin
      lat_pend = 1;
      lat_ref  = cyc;
    end
    @(negedge clk);
    i_ld = 0;
    if (junk) begin
      repeat (4) @(negedge clk);
      i_ld = 1; i_cnt = '0; i_x0 = 12'h555; i_iw = 24'h123456; // R9: must be ignored
      @(negedge clk);
      i_ld = 0;
    end
    while (!span_done) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(!o_valid && !o_busy && !o_done && !o_err, "R11", "reset state",
          {o_valid, o_busy, o_done, o_err}, 0);
    // R1 R2 R5: plain span, always ready
    run_span("R1/R2", 12'd10, 24'h010000, 24'hFF8000, 24'h800000,
             24'h000400, 24'h000200, 24'hFF8000, 12'd8, 0);
    // R8: random backpressure
    bp_mode = 1;
    run_span("R8/R1", 12'd100, 24'hFE4000, 24'h023000, 24'h400000,
             24'h001234, 24'hFFF111, 24'h010000, 12'd6, 0);
    bp_mode = 0;
    // R3: saturation boundary 2050..2047
    run_span("R3", 12'd7, 24'h000010, 24'hFFFFF0, 24'h000802,
             24'h000001, 24'h000000, 24'hFFFFFF, 12'd4, 0);
    // R4: 1/w reaching zero then wrapping
    run_span("R4", 12'd0, 24'h000300, 24'h000100, 24'h000002,
             24'h000000, 24'h000000, 24'hFFFFFF, 12'd4, 0);
    // R7: zero count
    n_stray = 0;
    run_span("R7", 12'd1, 24'h0, 24'h0, 24'h800000, 24'h0, 24'h0, 24'h0, 12'd0, 0);
    repeat (40) @(negedge clk);
    check(n_stray == 0 && !o_busy, "R7", "no output after zero count", n_stray, 0);
    // R9: load while busy, plus x wrap (R5)
    run_span("R9/R5", 12'hFFE, 24'h008000, 24'h7F0000, 24'h600000,
             24'h000800, 24'hFF0000, 24'h004000, 12'd4, 1);
    repeat (40) @(negedge clk);
    check(n_stray == 0 && !o_busy, "R9", "no output from ignored load", n_stray, 0);
    check(sbq.size() == 0, "R6", "all results seen", sbq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule